// File: doc/BRIEF.md
# Multi-Bank Flash Command Interpreter

This block is the command front end of a NOR-style flash device split into independent banks. Each accepted bus-write cycle carries an 8-bit command code plus the upper address bits that select a bank and an erase block. The block keeps a separate read mode for every bank: array data, status register, device identification words or a small query table. It holds the shared error bits of the status register and runs two-cycle block erase sequences. Each bank has its own background erase engine, which is modelled as a busy counter.

Reads arrive as a request carrying a full address. The response word comes one cycle later, taken from the source that the addressed bank's current mode selects. Array content is not stored. An erased block reads all ones. Any other location reads its own address XOR 0xA55A.

Both streams are valid/ready in spirit but never apply back-pressure. `cmd_ready` is held high, so a command transfers on every cycle in which `cmd_valid` is high. A read request is accepted on every cycle in which `rd_valid` is high. Its response appears on `rd_rvalid`/`rd_data` exactly one cycle later and must be consumed in that cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every bank is in array mode, all error bits are 0, no erase is running, and `cmd_ready` is 1.
- R2: Commands 0x90 (identification), 0x98 (query) and 0x70 (status) each take one write cycle and change only the addressed bank's read mode. Every other bank keeps its mode.
- R3: Read data depends on the addressed bank's mode:
  - Array mode returns the address XOR 0xA55A, or 0xFFFF for an erased block.
  - Status mode returns bit7 = engine not running, bit6 = suspended, and error bits 5, 4, 3 and 1, with all other bits 0.
  - Identification mode selects on address bits [1:0]: 0 gives 0x00A7, 1 gives 0x7E21, 2 gives the addressed block's protect bit, and 3 gives 0x1F4B.
  - Query mode returns 0x0051, 0x0052 and 0x0059 at offsets 0 to 2, and 0 at offsets 8 to 15.
- R4: Only 0xFF returns a bank to array mode. Clear status leaves the mode unchanged.
- R5: Command 0x50 clears error bits 1, 3, 4 and 5 on an idle bank and keeps that bank's mode. No other command clears an error bit.
- R6: Erase is 0x20 followed by 0xD0 on the next write cycle. The setup cycle puts the bank into status mode. The confirm cycle takes the block from the low field of `cmd_sel` and starts that bank's engine.
- R7: If the cycle after setup is not 0xD0, bits 4 and 5 are set and nothing is erased.
- R8: Confirming an erase on a protected block sets bits 1 and 5 and leaves the block's data unchanged.
- R9: The engine runs for ERASE_CYCLES clocks with bit7 = 0. After it finishes, the erased block reads 0xFFFF and neighbouring blocks are unchanged.
- R10: While its engine runs, a bank acts only on 0xFF, 0x70, 0x90, 0x98 and 0xB0. Identification and query reads work while the erase continues.
- R11: 0xB0 suspends a running erase, which shows as bit7 = 1 and bit6 = 1 with the count frozen. 0xD0 resumes it.
- R12: Taking `rst_n` low aborts any erase, and the block is not marked erased.
- R13: `rd_rvalid` is high exactly one cycle after `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts erases |
| cmd_valid | input | 1 | Command write cycle present |
| cmd_ready | output | 1 | Always 1; no back-pressure |
| cmd_sel | input | 4 | Upper address bits: bank in [3:2], block in [1:0] |
| cmd_code | input | 8 | Command code |
| prot_mask | input | 16 | Protect bit per block, index bank*4+block |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 16 | Read address: bank [15:14], block [13:12] |
| rd_data | output | 16 | Read response word |
| rd_rvalid | output | 1 | Response valid, one cycle after request |

## Verification
The assertions assume that `cmd_valid` and `rd_valid` carry no unknown values after reset, and that `prot_mask` holds steady around an erase confirm. The timing checks also assume `rst_n` is released away from the clock edge. The bench drives all inputs on falling edges from tasks. It changes `prot_mask` only before the first command and releases reset mid-cycle. It issues commands strictly in the sequences the requirements describe, so the decoder never sees an unknown code on a valid cycle.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_t;

  typedef enum logic [1:0] {
    EG_IDLE = 2'd0,
    EG_RUN  = 2'd1,
    EG_SUSP = 2'd2
  } eng_t;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_SIG     = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

  localparam int SR_RDY  = 7;
  localparam int SR_SUS  = 6;
  localparam int SR_ERS  = 5;
  localparam int SR_SEQ  = 4;
  localparam int SR_VPP  = 3;
  localparam int SR_PROT = 1;

  localparam logic [7:0] ERR_BITS      = 8'b0011_1010;
  localparam logic [7:0] SET_SEQ_FAIL  = 8'b0011_0000;
  localparam logic [7:0] SET_PROT_FAIL = 8'b0010_0010;

  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] MFR_ID     = 16'h00A7;
  localparam logic [DATA_W-1:0] DEV_ID     = 16'h7E21;
  localparam logic [DATA_W-1:0] CFG_WORD   = 16'h1F4B;
  localparam logic [DATA_W-1:0] ARRAY_SEED = 16'hA55A;
  localparam logic [DATA_W-1:0] ERASED_W   = 16'hFFFF;

  function automatic logic [DATA_W-1:0] query_word(input logic [3:0] idx);
    logic [DATA_W-1:0] w;
    case (idx)
      4'd0:    w = 16'h0051;
      4'd1:    w = 16'h0052;
      4'd2:    w = 16'h0059;
      4'd3:    w = 16'h0001;
      4'd4:    w = 16'h0004;
      4'd5:    w = 16'h0004;
      4'd6:    w = 16'h000A;
      4'd7:    w = 16'h0010;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fcc_bank.sv
module fcc_bank
  import fcc_pkg::*;
#(
  parameter int ERASE_CYCLES = 40,
  parameter int BLK_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  rmode_t           mode_d,
  input  logic             start,
  input  logic [BLK_W-1:0] start_blk,
  input  logic             suspend,
  input  logic             resume,
  output rmode_t           mode_o,
  output eng_t             state_o,
  output logic             done_o,
  output logic [BLK_W-1:0] blk_o
);

  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES);

  rmode_t           mode_q;
  eng_t             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RM_ARRAY;
    else if (mode_we) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EG_IDLE;
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      case (st_q)
        EG_IDLE: if (start) begin
          st_q  <= EG_RUN;
          cnt_q <= CNT_LOAD;
          blk_q <= start_blk;
        end
        EG_RUN: begin
          if (suspend) begin
            st_q <= EG_SUSP;
          end else if (cnt_q == CNT_W'(1)) begin
            st_q  <= EG_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        EG_SUSP: if (resume) st_q <= EG_RUN;
        default: st_q <= EG_IDLE;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign state_o = st_q;
  assign blk_o   = blk_q;
  assign done_o  = (st_q == EG_RUN) && !suspend && (cnt_q == CNT_W'(1));

  assert_start_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EG_IDLE && start) |=> (st_q == EG_RUN));

  assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EG_RUN) |-> (cnt_q != '0 && cnt_q <= CNT_LOAD));

  assert_suspend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EG_SUSP && !resume) |=> (st_q == EG_SUSP && $stable(cnt_q)));

endmodule

// File: rtl/fcc_status.sv
module fcc_status
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [7:0] set_bits,
  output logic [7:0] err_o
);

  logic [7:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= '0;
    else if (clr) err_q <= '0;
    else          err_q <= err_q | (set_bits & ERR_BITS);
  end

  assign err_o = err_q;

  assert_sticky_errors_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/fcc_rdmux.sv
module fcc_rdmux
  import fcc_pkg::*;
#(
  parameter int NUM_BANKS       = 4,
  parameter int BLOCKS_PER_BANK = 4,
  parameter int ADDR_W          = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   rd_valid,
  input  logic [ADDR_W-1:0]                      rd_addr,
  input  rmode_t [NUM_BANKS-1:0]                 modes_i,
  input  eng_t   [NUM_BANKS-1:0]                 states_i,
  input  logic [7:0]                             err_i,
  input  logic [NUM_BANKS*BLOCKS_PER_BANK-1:0]   erased_i,
  input  logic [NUM_BANKS*BLOCKS_PER_BANK-1:0]   prot_i,
  output logic [DATA_W-1:0]                      rd_data,
  output logic                                   rd_rvalid
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int BLK_W  = $clog2(BLOCKS_PER_BANK);
  localparam int SEL_W  = BANK_W + BLK_W;

  logic [BANK_W-1:0] bank;
  logic [SEL_W-1:0]  blk_idx;
  logic [7:0]        sr;
  logic [DATA_W-1:0] word;
  eng_t              st;

  assign bank    = rd_addr[ADDR_W-1 -: BANK_W];
  assign blk_idx = rd_addr[ADDR_W-1 -: SEL_W];
  assign st      = states_i[bank];

  always_comb begin
    sr = err_i & ERR_BITS;
    sr[SR_RDY] = (st != EG_RUN);
    sr[SR_SUS] = (st == EG_SUSP);
  end

  always_comb begin
    case (modes_i[bank])
      RM_ARRAY:  word = erased_i[blk_idx] ? ERASED_W : (rd_addr ^ ARRAY_SEED);
      RM_STATUS: word = {8'h00, sr};
      RM_SIG: begin
        case (rd_addr[1:0])
          2'd0:    word = MFR_ID;
          2'd1:    word = DEV_ID;
          2'd2:    word = {15'd0, prot_i[blk_idx]};
          default: word = CFG_WORD;
        endcase
      end
      default:   word = query_word(rd_addr[3:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_rvalid <= 1'b0;
    end else begin
      rd_rvalid <= rd_valid;
      if (rd_valid) rd_data <= word;
    end
  end

  assert_resp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_rvalid);

  assert_no_stray_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_rvalid);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int NUM_BANKS       = 4,
  parameter int BLOCKS_PER_BANK = 4,
  parameter int ADDR_W          = 16,
  parameter int ERASE_CYCLES    = 40
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                cmd_valid,
  output logic                                                cmd_ready,
  input  logic [$clog2(NUM_BANKS)+$clog2(BLOCKS_PER_BANK)-1:0] cmd_sel,
  input  logic [7:0]                                          cmd_code,
  input  logic [NUM_BANKS*BLOCKS_PER_BANK-1:0]                prot_mask,
  input  logic                                                rd_valid,
  input  logic [ADDR_W-1:0]                                   rd_addr,
  output logic [15:0]                                         rd_data,
  output logic                                                rd_rvalid
);

  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int BLK_W      = $clog2(BLOCKS_PER_BANK);
  localparam int SEL_W      = BANK_W + BLK_W;
  localparam int NUM_BLOCKS = NUM_BANKS * BLOCKS_PER_BANK;

  logic              fire;
  logic [BANK_W-1:0] w_bank;
  logic [BLK_W-1:0]  w_blk;
  logic              pend_q;
  logic [BANK_W-1:0] pend_bank_q;

  rmode_t [NUM_BANKS-1:0]            bank_mode;
  eng_t   [NUM_BANKS-1:0]            bank_state;
  logic   [NUM_BANKS-1:0]            bank_done;
  logic   [NUM_BANKS-1:0][BLK_W-1:0] bank_blk;
  logic   [NUM_BLOCKS-1:0]           erased_q;
  logic   [7:0]                      err;

  logic [BANK_W-1:0] tgt_bank;
  logic              mode_we_v, start_v, susp_v, res_v, clr_v, pend_set;
  rmode_t            mode_d_v;
  logic [7:0]        set_bits;
  eng_t              st_w;

  assign cmd_ready = 1'b1;
  assign fire      = cmd_valid;
  assign w_bank    = cmd_sel[SEL_W-1 -: BANK_W];
  assign w_blk     = cmd_sel[BLK_W-1:0];
  assign st_w      = bank_state[w_bank];

  // Command decode: one write cycle, routed to a single target bank.
  always_comb begin
    tgt_bank  = w_bank;
    mode_we_v = 1'b0;
    mode_d_v  = RM_ARRAY;
    start_v   = 1'b0;
    susp_v    = 1'b0;
    res_v     = 1'b0;
    clr_v     = 1'b0;
    pend_set  = 1'b0;
    set_bits  = '0;
    if (fire) begin
      if (pend_q) begin
        tgt_bank = pend_bank_q;
        if (cmd_code == OP_CONFIRM) begin
          if (prot_mask[{pend_bank_q, w_blk}]) set_bits = SET_PROT_FAIL;
          else                                 start_v  = 1'b1;
        end else begin
          set_bits = SET_SEQ_FAIL;
        end
      end else begin
        case (cmd_code)
          OP_ARRAY:   begin mode_we_v = 1'b1; mode_d_v = RM_ARRAY;  end
          OP_STATUS:  begin mode_we_v = 1'b1; mode_d_v = RM_STATUS; end
          OP_SIG:     begin mode_we_v = 1'b1; mode_d_v = RM_SIG;    end
          OP_QUERY:   begin mode_we_v = 1'b1; mode_d_v = RM_QUERY;  end
          OP_CLEAR:   clr_v = (st_w == EG_IDLE);
          OP_ERASE: if (st_w == EG_IDLE) begin
            pend_set  = 1'b1;
            mode_we_v = 1'b1;
            mode_d_v  = RM_STATUS;
          end
          OP_SUSPEND: susp_v = (st_w == EG_RUN);
          OP_CONFIRM: res_v  = (st_w == EG_SUSP);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_bank_q <= '0;
    end else if (fire) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (pend_set) begin
        pend_q      <= 1'b1;
        pend_bank_q <= w_bank;
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (tgt_bank == BANK_W'(b));

    fcc_bank #(
      .ERASE_CYCLES(ERASE_CYCLES),
      .BLK_W       (BLK_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (mode_we_v && hit),
      .mode_d   (mode_d_v),
      .start    (start_v && hit),
      .start_blk(w_blk),
      .suspend  (susp_v && hit),
      .resume   (res_v && hit),
      .mode_o   (bank_mode[b]),
      .state_o  (bank_state[b]),
      .done_o   (bank_done[b]),
      .blk_o    (bank_blk[b])
    );

    assert_other_bank_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !pend_q && w_bank != BANK_W'(b)) |=> $stable(bank_mode[b]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_done[b]) erased_q[b*BLOCKS_PER_BANK + int'(bank_blk[b])] <= 1'b1;
      end
    end
  end

  fcc_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_v),
    .set_bits(set_bits),
    .err_o   (err)
  );

  fcc_rdmux #(
    .NUM_BANKS      (NUM_BANKS),
    .BLOCKS_PER_BANK(BLOCKS_PER_BANK),
    .ADDR_W         (ADDR_W)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .modes_i  (bank_mode),
    .states_i (bank_state),
    .err_i    (err),
    .erased_i (erased_q),
    .prot_i   (prot_mask),
    .rd_data  (rd_data),
    .rd_rvalid(rd_rvalid)
  );

  assert_bad_confirm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pend_q && cmd_code != OP_CONFIRM) |=> (err[SR_SEQ] && err[SR_ERS]));

  assert_busy_no_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pend_q && st_w == EG_RUN && cmd_code == OP_ERASE) |=> !pend_q);

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int N = 40;
  localparam logic [15:0] SEED = 16'hA55A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_sel = '0;
  logic [7:0]  cmd_code = '0;
  logic [15:0] prot_mask = 16'h0800;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_rvalid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic last_rvalid;

  flash_cmd_ctrl #(.ERASE_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_code(cmd_code), .prot_mask(prot_mask),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_rvalid(rd_rvalid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] A(input int bank, input int blk, input int off);
    return {bank[1:0], blk[1:0], off[11:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int bank, input int blk, input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_sel   = {bank[1:0], blk[1:0]};
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] addr, output logic [15:0] data);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = addr;
    @(negedge clk);
    rd_valid    = 1'b0;
    data        = rd_data;
    last_rvalid = rd_rvalid;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 cmd_ready", {15'd0, cmd_ready}, 16'd1);
    rd(A(0, 0, 12'h012), d); chk("R1 array after reset", d, A(0, 0, 12'h012) ^ SEED);
    chk("R13 rvalid next cycle", {15'd0, last_rvalid}, 16'd1);
    rd(A(3, 2, 1), d); chk("R1 bank3 array", d, A(3, 2, 1) ^ SEED);
    wr(0, 0, 8'h70);
    rd(A(0, 0, 0), d); chk("R1 status clean", d, 16'h0080);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    wr(1, 0, 8'h90);
    rd(A(1, 0, 0), d); chk("R3 mfr id", d, 16'h00A7);
    rd(A(1, 0, 1), d); chk("R3 dev id", d, 16'h7E21);
    rd(A(1, 0, 2), d); chk("R3 lock bit clear", d, 16'h0000);
    rd(A(1, 0, 3), d); chk("R3 cfg word", d, 16'h1F4B);
    rd(A(2, 1, 4), d); chk("R2 bank2 still array", d, A(2, 1, 4) ^ SEED);
    rd(A(0, 0, 0), d); chk("R2 bank0 still status", d, 16'h0080);
    wr(2, 0, 8'h98);
    rd(A(2, 0, 0), d); chk("R3 query 0", d, 16'h0051);
    rd(A(2, 0, 1), d); chk("R3 query 1", d, 16'h0052);
    rd(A(2, 0, 2), d); chk("R3 query 2", d, 16'h0059);
    rd(A(2, 0, 9), d); chk("R3 query 9", d, 16'h0000);
    rd(A(1, 0, 0), d); chk("R2 bank1 keeps sig", d, 16'h00A7);
  endtask

  task automatic t_return();
    logic [15:0] d;
    wr(1, 0, 8'h50);
    rd(A(1, 0, 1), d); chk("R4 clear keeps sig", d, 16'h7E21);
    wr(1, 0, 8'hFF);
    rd(A(1, 3, 6), d); chk("R4 back to array", d, A(1, 3, 6) ^ SEED);
    wr(2, 0, 8'hFF);
    rd(A(2, 0, 6), d); chk("R4 query to array", d, A(2, 0, 6) ^ SEED);
  endtask

  task automatic t_bad_confirm();
    logic [15:0] d;
    wr(0, 0, 8'h20);
    wr(0, 0, 8'h55);
    rd(A(0, 0, 0), d); chk("R7 seq error bits", d, 16'h00B0);
    wr(0, 0, 8'hFF);
    rd(A(0, 0, 4), d); chk("R7 no erase", d, A(0, 0, 4) ^ SEED);
    wr(0, 0, 8'h90);
    wr(0, 0, 8'h70);
    rd(A(0, 0, 0), d); chk("R5 errors sticky", d, 16'h00B0);
    wr(0, 0, 8'h50);
    rd(A(0, 0, 0), d); chk("R5 cleared, status mode kept", d, 16'h0080);
  endtask

  task automatic t_protect();
    logic [15:0] d;
    wr(2, 0, 8'h20);
    wr(2, 3, 8'hD0);
    rd(A(2, 0, 0), d); chk("R8 protect error", d, 16'h00A2);
    wr(2, 0, 8'hFF);
    rd(A(2, 3, 8), d); chk("R8 protected data kept", d, A(2, 3, 8) ^ SEED);
    wr(2, 0, 8'h50);
  endtask

  task automatic t_erase();
    logic [15:0] d;
    int c0;
    wr(1, 0, 8'h20);
    wr(1, 2, 8'hD0);
    c0 = cyc;
    rd(A(1, 0, 0), d); chk("R6 status mode busy", d, 16'h0000);
    wr(1, 0, 8'h90);
    rd(A(1, 0, 0), d); chk("R10 sig during erase", d, 16'h00A7);
    rd(A(1, 0, 1), d); chk("R10 dev during erase", d, 16'h7E21);
    wr(1, 0, 8'h20);
    wr(1, 0, 8'h70);
    rd(A(1, 0, 0), d); chk("R10 setup ignored while busy", d, 16'h0000);
    while (cyc < c0 + N - 4) @(negedge clk);
    rd(A(1, 0, 0), d); chk("R9 still busy near end", d, 16'h0000);
    while (cyc < c0 + N + 2) @(negedge clk);
    rd(A(1, 0, 0), d); chk("R9 ready after count", d, 16'h0080);
    wr(1, 0, 8'hFF);
    rd(A(1, 2, 5), d); chk("R9 erased block", d, 16'hFFFF);
    rd(A(1, 1, 5), d); chk("R9 neighbour kept", d, A(1, 1, 5) ^ SEED);
  endtask

  task automatic t_suspend();
    logic [15:0] d;
    wr(3, 0, 8'h20);
    wr(3, 0, 8'hD0);
    wr(3, 0, 8'hB0);
    rd(A(3, 0, 0), d); chk("R11 suspended status", d, 16'h00C0);
    repeat (2 * N) @(negedge clk);
    rd(A(3, 0, 0), d); chk("R11 frozen while suspended", d, 16'h00C0);
    wr(3, 0, 8'hD0);
    rd(A(3, 0, 0), d); chk("R11 resumed busy", d, 16'h0000);
    repeat (N + 5) @(negedge clk);
    rd(A(3, 0, 0), d); chk("R11 done after resume", d, 16'h0080);
    wr(3, 0, 8'hFF);
    rd(A(3, 0, 7), d); chk("R11 block erased", d, 16'hFFFF);
  endtask

  task automatic t_reset_abort();
    logic [15:0] d;
    wr(0, 0, 8'h20);
    wr(0, 1, 8'hD0);
    repeat (5) @(negedge clk);
    rd(A(0, 0, 0), d); chk("R12 busy before reset", d, 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(A(1, 2, 5), d); chk("R12 bank1 array after reset", d, A(1, 2, 5) ^ SEED);
    wr(0, 0, 8'h70);
    rd(A(0, 0, 0), d); chk("R12 idle after reset", d, 16'h0080);
    repeat (N + 5) @(negedge clk);
    wr(0, 0, 8'hFF);
    rd(A(0, 1, 3), d); chk("R12 block not erased", d, A(0, 1, 3) ^ SEED);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_return();
    t_bad_confirm();
    t_protect();
    t_erase();
    t_suspend();
    t_reset_abort();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

endmodule